// File: doc/BRIEF.md
# Clear-on-read interrupt controller

This block gathers interrupt conditions of a link transmitter into a single active-low, open-drain style request line. A control register holds a master enable in bit 0 and one enable per condition in bits 1 to 7. A status register records which enabled conditions have fired. Internal conditions arrive as single-cycle pulses. The receiver condition in bit 5 instead comes from an external active-low pin. That pin is synchronized and only its falling edges count, so an interrupt from a downstream receiver is passed upstream exactly once per edge.

Host software services the line by reading the status register. That read returns the latched bits plus a summary bit, and it also clears them all, which releases the line. A third, read-only register shows the current synchronized level of the external pin. This lets software see whether the receiver still holds its request.

The output logic is a two-state machine. In `ST_QUIET` the line is released. In `ST_ALERT` it pulls low. There are two transitions:
- `ST_QUIET` moves to `ST_ALERT` ("raise") when the master enable is set and some latched bit has its enable set.
- `ST_ALERT` moves back to `ST_QUIET` ("drop") when that is no longer true, for example after a clearing read.

Top module: `link_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00 and `irq_no` is 1 with `irq_pull_o` at 0.
- R2: The control register at address 0xC6 is read/write. A read returns the last value written.
- R3: A pulse on `evt_pulse_i` bit n, for n in {1,2,3,4,6,7}, sets status bit n only if control bit n is 1. Bits 0 and 5 of `evt_pulse_i` are ignored.
- R4: Status bit 0, read at address 0xC7, is 1 exactly when any of status bits 7..1 is 1.
- R5: One cycle after the status and control registers hold a value where control bit 0 is 1 and (status[7:1] & control[7:1]) is nonzero, `irq_no` is 0. Otherwise it is 1. With control bit 0 clear the line never pulls low.
- R6: A read of 0xC7 clears all status bits at that clock edge, and `irq_no` returns to 1 one cycle later. An event pulse that arrives in the same cycle as the clearing read stays latched.
- R7: A falling edge of `ext_irq_ni`, seen after a two-flop synchronizer, sets status bit 5 when control bit 5 is 1. A pin that stays low after a clearing read does not set the bit again.
- R8: Address 0xC8 is read-only. Its bit 5 is the synchronized level of `ext_irq_ni` and all its other bits are 0. Reading it clears nothing.
- R9: Writes to 0xC7 or 0xC8 change no register. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_ni | input | 1 | External receiver interrupt, active low, asynchronous |
| evt_pulse_i | input | 8 | Internal condition pulses, one bit per condition |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, valid in the cycle of `rd_en_i` |
| irq_pull_o | output | 1 | 1 while the block pulls the shared line low |
| irq_no | output | 1 | Modelled open-drain request line, active low |

## Verification
The bench uses the default parameters: 8-bit data, the receiver condition in bit 5, two synchronizer stages and register addresses 0xC6, 0xC7 and 0xC8. With these values the full set of condition bits can be covered by random event masks, and the pin-to-status latency is short enough to count exactly. A seeded random phase mixes control writes, clearing reads and event pulses while the pin is idle, and a bench model tracks the results. Directed cases then cover a pin that is held low, an event colliding with a read, a master enable that is off, and ignored writes.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_ni,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[0] <= 1'b1;
                    else         chain_q[0] <= pin_ni;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[s] <= 1'b1;
                    else         chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b1;
        else         prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];

    // A detected edge is a single-cycle pulse.
    assert_fall_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] evt_i,
    input  logic [DW-1:0] en_i,
    input  logic          clr_i,
    output logic [DW-1:0] status_o
);
    localparam int NC = DW - 1;

    logic [NC:1] flags_q;
    logic [NC:1] set_w;
    logic [NC:1] flags_d;

    assign set_w = evt_i[NC:1] & en_i[NC:1];

    always_comb begin
        flags_d = clr_i ? '0 : flags_q;
        flags_d = flags_d | set_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flags_q <= '0;
        else         flags_q <= flags_d;
    end

    assign status_o = {flags_q, |flags_q};

    assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !(|set_w)) |=> (flags_q == '0));

    generate
        for (genvar b = 1; b <= NC; b++) begin : g_chk
            assert_latch_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(flags_q[b]) |-> ($past(en_i[b]) && $past(evt_i[b])));
        end
    endgenerate
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import link_irq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] ctrl_i,
    output logic          drive_low_o
);
    irq_state_e state_q, state_d;
    logic       fire_w;

    assign fire_w = ctrl_i[0] & (|(status_i[DW-1:1] & ctrl_i[DW-1:1]));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (fire_w)  state_d = ST_ALERT;
            ST_ALERT: if (!fire_w) state_d = ST_QUIET;
            default:               state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_QUIET;
        else         state_q <= state_d;
    end

    always_comb begin
        drive_low_o = (state_q == ST_ALERT);
    end

    assert_master_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(ctrl_i[0]) |-> !drive_low_o);

    assert_drive_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_low_o |-> $past(|status_i[DW-1:1]));
endmodule

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl #(
    parameter int          DW          = 8,
    parameter int          AW          = 8,
    parameter int          RX_BIT      = 5,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CTRL_ADDR   = 8'hC6,
    parameter logic [7:0]  STAT_ADDR   = 8'hC7,
    parameter logic [7:0]  LIVE_ADDR   = 8'hC8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ext_irq_ni,
    input  logic [DW-1:0] evt_pulse_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_pull_o,
    output logic          irq_no
);
    localparam logic [AW-1:0] A_CTRL = AW'(CTRL_ADDR);
    localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);
    localparam logic [AW-1:0] A_LIVE = AW'(LIVE_ADDR);

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] status_w;
    logic [DW-1:0] evt_w;
    logic          rx_level_w;
    logic          rx_fall_w;
    logic          clr_w;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_ni  (ext_irq_ni),
        .level_o (rx_level_w),
        .fall_o  (rx_fall_w)
    );

    generate
        for (genvar b = 0; b < DW; b++) begin : g_evt
            if (b == 0) begin : g_sum
                assign evt_w[b] = 1'b0;
            end else if (b == RX_BIT) begin : g_rx
                assign evt_w[b] = rx_fall_w;
            end else begin : g_int
                assign evt_w[b] = evt_pulse_i[b];
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          ctrl_q <= '0;
        else if (wr_en_i && addr_i == A_CTRL) ctrl_q <= wr_data_i;
    end

    assign clr_w = rd_en_i && (addr_i == A_STAT);

    irq_status_bank #(.DW(DW)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .evt_i    (evt_w),
        .en_i     (ctrl_q),
        .clr_i    (clr_w),
        .status_o (status_w)
    );

    irq_out_fsm #(.DW(DW)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .status_i    (status_w),
        .ctrl_i      (ctrl_q),
        .drive_low_o (irq_pull_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            if (addr_i == A_CTRL)      rd_data_o = ctrl_q;
            else if (addr_i == A_STAT) rd_data_o = status_w;
            else if (addr_i == A_LIVE) rd_data_o[RX_BIT] = rx_level_w;
        end
    end

    assign irq_no = irq_pull_o ? 1'b0 : 1'b1;

    assert_rx_from_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_w[RX_BIT]) |-> $past(rx_fall_w));
endmodule

// File: tb/link_irq_ctrl_test.sv
`timescale 1ns/1ps
module link_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_n = 1'b1;
    logic [7:0] evt = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       pull, irq_n;
    int         n_cmp = 0, n_bad = 0;

    link_irq_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .ext_irq_ni(pin_n), .evt_pulse_i(evt),
        .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wr_data_i(wdata),
        .rd_data_o(rdata), .irq_pull_o(pull), .irq_no(irq_n)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic logic fire(input logic [7:0] st, input logic [7:0] ct);
        return ct[0] & (|(st[7:1] & ct[7:1]));
    endfunction

    function automatic logic [7:0] nxt(input logic [7:0] st, input logic [7:0] ct,
                                       input logic [7:0] ev, input logic clr);
        logic [7:0] f;
        f = clr ? 8'h00 : st;
        f = f | (ev & ct & 8'hDE);
        f[0] = 1'b0;
        return f;
    endfunction

    function automatic logic [7:0] view(input logic [7:0] st);
        return {st[7:1], |st[7:1]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Called at a negedge; applies inputs for one cycle, returns read data.
    task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                       input logic [7:0] wd, input logic [7:0] ev, output logic [7:0] rv);
        wr = w; rd = r; addr = a; wdata = wd; evt = ev;
        #1 rv = rdata;
        @(posedge clk);
        @(negedge clk);
        wr = 0; rd = 0; evt = '0; addr = '0; wdata = '0;
    endtask

    task automatic idle(input int n);
        logic [7:0] d;
        for (int k = 0; k < n; k++) cyc(0, 0, 8'h00, 8'h00, 8'h00, d);
    endtask

    initial begin
        logic [7:0] rv, st, ct;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        cyc(0, 1, 8'hC6, 0, 0, rv); check("R1 ctrl", rv, 8'h00);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R1 status", rv, 8'h00);

        // R2 control read-back
        cyc(1, 0, 8'hC6, 8'hA5, 0, rv);
        cyc(0, 1, 8'hC6, 0, 0, rv); check("R2 readback", rv, 8'hA5);
        cyc(1, 0, 8'hC6, 8'h00, 0, rv);

        // Random phase with model (R3 R4 R5 R6)
        st = 8'h00; ct = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            int unsigned op;
            logic [7:0] ev, o_st, o_ct, wv;
            op = $urandom_range(0, 9);
            ev = (($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00) & 8'hDE;
            o_st = st; o_ct = ct;
            wv = 8'($urandom);
            if (op == 0) begin
                cyc(1, 0, 8'hC6, wv, ev, rv); ct = wv;
                st = nxt(o_st, o_ct, ev, 1'b0);
            end else if (op <= 2) begin
                cyc(0, 1, 8'hC7, 0, ev, rv);
                check("R4/R6 status read", rv, view(o_st));
                st = nxt(o_st, o_ct, ev, 1'b1);
            end else if (op == 3) begin
                cyc(0, 1, 8'hC6, 0, ev, rv);
                check("R2 ctrl read", rv, o_ct);
                st = nxt(o_st, o_ct, ev, 1'b0);
            end else begin
                cyc(0, 0, 8'h00, 0, ev, rv);
                st = nxt(o_st, o_ct, ev, 1'b0);
            end
            check("R5 irq_n", {7'd0, irq_n}, {7'd0, ~fire(o_st, o_ct)});
        end
        cyc(0, 1, 8'hC7, 0, 0, rv);

        // R3 ignored event bits 0 and 5
        cyc(1, 0, 8'hC6, 8'hFF, 0, rv);
        cyc(0, 0, 8'h00, 0, 8'h21, rv);
        idle(1);
        check("R3 bits0/5 ignored irq", {7'd0, irq_n}, 8'h01);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R3 bits0/5 ignored", rv, 8'h00);

        // R3 disabled condition does not latch
        cyc(1, 0, 8'hC6, 8'hF5, 0, rv);
        cyc(0, 0, 8'h00, 0, 8'h02, rv);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R3 disabled no latch", rv, 8'h00);

        // R5 master enable off: latched but line stays high
        cyc(1, 0, 8'hC6, 8'hFE, 0, rv);
        cyc(0, 0, 8'h00, 0, 8'h08, rv);
        idle(2);
        check("R5 master off irq", {7'd0, irq_n}, 8'h01);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R4 master off status", rv, 8'h09);

        // R6 event colliding with clearing read wins
        cyc(1, 0, 8'hC6, 8'h07, 0, rv);
        cyc(0, 0, 8'h00, 0, 8'h04, rv);
        cyc(0, 1, 8'hC7, 0, 8'h02, rv); check("R6 read before clear", rv, 8'h05);
        check("R6 irq asserted", {7'd0, irq_n}, 8'h00);
        idle(1);
        check("R6 irq held by new event", {7'd0, irq_n}, 8'h00);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R6 event kept", rv, 8'h03);
        idle(1);
        check("R6 release", {7'd0, irq_n}, 8'h01);

        // R9 writes to status and live ignored, unmapped reads zero
        cyc(0, 0, 8'h00, 0, 8'h04, rv);
        cyc(1, 0, 8'hC7, 8'hFF, 0, rv);
        cyc(1, 0, 8'hC8, 8'hFF, 0, rv);
        cyc(0, 1, 8'hC6, 0, 0, rv); check("R9 ctrl untouched", rv, 8'h07);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R9 status untouched", rv, 8'h05);
        cyc(0, 1, 8'h3A, 0, 0, rv); check("R9 unmapped", rv, 8'h00);

        // R7/R8 external pin
        cyc(1, 0, 8'hC6, 8'h21, 0, rv);
        cyc(0, 1, 8'hC8, 0, 0, rv); check("R8 live high", rv, 8'h20);
        pin_n = 1'b0;
        idle(4);
        check("R7 irq from pin", {7'd0, irq_n}, 8'h00);
        cyc(0, 1, 8'hC8, 0, 0, rv); check("R8 live low", rv, 8'h00);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R7 status pin", rv, 8'h21);
        idle(6);
        check("R7 held low stays released", {7'd0, irq_n}, 8'h01);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R7 no relatch", rv, 8'h00);
        cyc(0, 1, 8'hC8, 0, 0, rv); check("R8 live no clear", rv, 8'h00);
        pin_n = 1'b1;
        idle(4);
        cyc(0, 1, 8'hC8, 0, 0, rv); check("R8 live back high", rv, 8'h20);
        pin_n = 1'b0;
        idle(4);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R7 second edge", rv, 8'h21);
        pin_n = 1'b1;
        idle(4);
        cyc(1, 0, 8'hC6, 8'h01, 0, rv);
        pin_n = 1'b0;
        idle(5);
        cyc(0, 1, 8'hC7, 0, 0, rv); check("R7 disabled pin", rv, 8'h00);
        check("R7 disabled irq", {7'd0, irq_n}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule